// File: doc/BRIEF.md
# Character Translation Store with Delimiter Hold

This block sits in the character path of a line-printer controller. Each incoming byte indexes a lookup store of 2^CHAR_W entries, 12 bits wide. The entry decides what the byte does. It can replace the byte with the entry's low character field, mark the byte as a delimiter, flag it as a paper-motion command with a 5-bit argument, or stop the stream and raise an undefined-character flag.

A delimiter arms a hold state. The next byte processed is then treated as translated, whatever its own translate bit says. The hold clears after that byte unless the byte is itself a delimiter.

The same store can be filled in two ways:
- A host loads one entry at a time, selected by a host-writable character buffer. While the stream is idle, the host reads that entry back with a computed parity bit.
- A run in load mode writes entries from a stream of byte pairs.

Only one run is active at a time. It starts with `go_start` (print or load, chosen by `load_mode`) and ends with `go_stop` or an interrupt entry.

Top module: `xlat_top`

## Requirements
- R1: After reset, the entries at indices 0x0A, 0x0B, 0x0C and 0x0D hold paper-instruction entries with translate set and arguments 7, 6, 0 and 0x10. These read back as 0x1307, 0x0306, 0x0300 and 0x1310. Every other entry is zero. After reset the run flag, the undefined flag and the hold flag are all low.
- R2: Entry layout: bits [7:0] are the character, bit 8 is paper instruction, bit 9 is translate, bit 10 is delimiter and bit 11 is interrupt. While idle, `ent_we` writes `ent_wdata` to the entry selected by the character buffer. `rd_word` returns that entry in bits [11:0], and bit 12 is set when the XOR of the 12 data bits is 1.
- R3: In a print run, a byte whose entry has the translate bit set is output as the entry's bits [7:0].
- R4: In a print run, a byte whose entry has neither the translate bit nor a pending hold is output unchanged.
- R5: A byte whose entry has bit 8 set produces a one-cycle `pi_valid` with `pi_arg` equal to entry bits [4:0], and no character output.
- R6: A character value of zero that is not a paper instruction produces no output pulse.
- R7: A byte whose entry has the delimiter bit sets `dhold`. The next processed byte is output as its entry's bits [7:0], and `dhold` then takes that entry's delimiter bit.
- R8: A byte whose entry has the interrupt bit ends the run and sets `und_flag`. Later bytes produce no output until a new start.
- R9: In a load run, the first byte of each pair writes entry bits [7:0], the second byte writes bits [11:8] from its low 4 bits, and then the index advances, starting from index 0.
- R10: `go_start` clears `und_flag` and restarts load pairing at index 0 and at the first byte of a pair.
- R11: Stream bytes offered while no run is active are ignored. Host entry writes made during a run are ignored.
- R12: Each processed byte updates the outputs on the clock edge that accepts it. The output pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_we | input | 1 | Load the character buffer |
| buf_wdata | input | CHAR_W | Character buffer value (host entry index) |
| ent_we | input | 1 | Host write of the selected entry (idle only) |
| ent_wdata | input | 12 | Entry value to write |
| rd_word | output | 13 | Selected entry with parity in bit 12 (valid while idle) |
| go_start | input | 1 | Start a run |
| load_mode | input | 1 | Run kind at start: 0 print, 1 load |
| go_stop | input | 1 | End the run |
| in_valid | input | 1 | Stream byte present |
| in_byte | input | CHAR_W | Stream byte |
| busy | output | 1 | Run active |
| out_valid | output | 1 | Character output pulse |
| out_byte | output | 8 | Output character |
| pi_valid | output | 1 | Paper-instruction pulse |
| pi_arg | output | 5 | Paper-instruction argument |
| und_flag | output | 1 | Undefined-character stop seen |
| dhold | output | 1 | Delimiter hold pending |

## Verification
The print run is fed with a set of byte classes:
- a translated byte and an untranslated byte, which separate substitution from pass-through;
- bytes whose entries map to zero, which separate suppression from output;
- paper-motion bytes, which show the argument path and that no character is emitted.

A delimiter followed by an untranslated byte shows that the hold forces substitution exactly once. A delimiter followed by a paper-motion byte shows that the hold clears. Byte pairs in a load run, read back through the parity port, expose pair order and index reset. Bytes and host writes offered at the wrong time show that they are ignored.

// File: rtl/xlat_pkg.sv
// Package: entry field positions and reset contents of the translation store.
// Assumes a 12-bit entry with a fixed field layout.
package xlat_pkg;
    localparam int ENT_W   = 12;
    localparam int CH_W    = 8;
    localparam int ARG_W   = 5;
    localparam int B_PI    = 8;
    localparam int B_TRN   = 9;
    localparam int B_DEL   = 10;
    localparam int B_INT   = 11;

    // Reset value of one entry: control codes become paper-motion commands.
    function automatic logic [ENT_W-1:0] default_entry(input int idx);
        case (idx)
            10:      default_entry = 12'h307;
            11:      default_entry = 12'h306;
            12:      default_entry = 12'h300;
            13:      default_entry = 12'h310;
            default: default_entry = '0;
        endcase
    endfunction
endpackage

// File: rtl/xlat_store.sv
// Single-ported translation store with asynchronous read.
// Assumes one write per cycle. Reset loads the default entries.
module xlat_store
    import xlat_pkg::*;
#(
    parameter int AW    = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [ENT_W-1:0] wdata,
    output logic [ENT_W-1:0] rdata
);
    logic [ENT_W-1:0] mem [DEPTH];

    // Write port, with default contents on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= default_entry(i);
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Read port.
    always_comb rdata = mem[addr];

    // R2
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (addr != $past(addr)) || (rdata == $past(wdata)));
endmodule

// File: rtl/xlat_loader.sv
// Pair sequencer for load runs: builds each entry from two bytes.
// Assumes the current entry at idx is presented on cur_entry.
module xlat_loader
    import xlat_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             take,
    input  logic [CH_W-1:0]  byte_in,
    input  logic [ENT_W-1:0] cur_entry,
    output logic [AW-1:0]    idx,
    output logic [ENT_W-1:0] wdata
);
    logic second;

    // Pair phase and index.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            second <= 1'b0;
            idx    <= '0;
        end else if (take) begin
            second <= ~second;
            if (second) idx <= idx + 1'b1;
        end
    end

    // Merged write data for the current phase.
    always_comb begin
        if (second) wdata = {byte_in[3:0], cur_entry[7:0]};
        else        wdata = {cur_entry[11:8], byte_in};
    end

    // R9
    pair_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !restart) |=> (second != $past(second)));
endmodule

// File: rtl/xlat_decode.sv
// Decodes one entry for a byte in a print run. Purely combinational.
// Assumes the entry was read at the index given by the byte.
module xlat_decode
    import xlat_pkg::*;
(
    input  logic [CH_W-1:0]  byte_in,
    input  logic [ENT_W-1:0] entry,
    input  logic             hold_in,
    output logic [CH_W-1:0]  ch_out,
    output logic             print,
    output logic             pi,
    output logic [ARG_W-1:0] arg,
    output logic             stop,
    output logic             hold_next
);
    // Substitution and action selection.
    always_comb begin
        ch_out    = (entry[B_TRN] || hold_in) ? entry[CH_W-1:0] : byte_in;
        pi        = entry[B_PI];
        arg       = entry[ARG_W-1:0];
        print     = !pi && (ch_out != '0);
        stop      = entry[B_INT];
        hold_next = entry[B_DEL];
    end
endmodule

// File: rtl/xlat_top.sv
// Translation unit top: run control, store port arbitration, output registers.
// Assumes go_start and go_stop are not asserted together with a stream byte.
module xlat_top
    import xlat_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [CHAR_W-1:0] buf_wdata,
    input  logic              ent_we,
    input  logic [ENT_W-1:0]  ent_wdata,
    output logic [ENT_W:0]    rd_word,
    input  logic              go_start,
    input  logic              load_mode,
    input  logic              go_stop,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_byte,
    output logic              busy,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_byte,
    output logic              pi_valid,
    output logic [ARG_W-1:0]  pi_arg,
    output logic              und_flag,
    output logic              dhold
);
    logic              go_q, mode_q, und_q, hold_q;
    logic [CHAR_W-1:0] buf_q;
    logic [CHAR_W-1:0] addr, ld_idx;
    logic [ENT_W-1:0]  rdata, ld_wdata, mem_wdata;
    logic              mem_we, take, take_prt, take_ld;
    logic [CH_W-1:0]   d_ch;
    logic              d_print, d_pi, d_stop, d_hold;
    logic [ARG_W-1:0]  d_arg;
    logic              ov_q, pv_q;
    logic [CH_W-1:0]   ob_q;
    logic [ARG_W-1:0]  pa_q;

    // Byte acceptance and port arbitration.
    always_comb begin
        take      = go_q && in_valid;
        take_prt  = take && !mode_q;
        take_ld   = take && mode_q;
        addr      = go_q ? (mode_q ? ld_idx : in_byte) : buf_q;
        mem_we    = take_ld || (!go_q && ent_we);
        mem_wdata = take_ld ? ld_wdata : ent_wdata;
        rd_word   = {^rdata, rdata};
    end

    xlat_store #(.AW(CHAR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(mem_we),
        .wdata(mem_wdata), .rdata(rdata)
    );

    xlat_loader #(.AW(CHAR_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .restart(go_start), .take(take_ld),
        .byte_in(in_byte[CH_W-1:0]), .cur_entry(rdata), .idx(ld_idx),
        .wdata(ld_wdata)
    );

    xlat_decode u_decode (
        .byte_in(in_byte[CH_W-1:0]), .entry(rdata), .hold_in(hold_q),
        .ch_out(d_ch), .print(d_print), .pi(d_pi), .arg(d_arg),
        .stop(d_stop), .hold_next(d_hold)
    );

    // Host character buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (buf_we) buf_q <= buf_wdata;
    end

    // Run control, undefined flag and delimiter hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            mode_q <= 1'b0;
            und_q  <= 1'b0;
            hold_q <= 1'b0;
        end else if (go_start) begin
            go_q   <= 1'b1;
            mode_q <= load_mode;
            und_q  <= 1'b0;
        end else if (go_stop) begin
            go_q   <= 1'b0;
        end else if (take_prt) begin
            hold_q <= d_hold;
            if (d_stop) begin
                go_q  <= 1'b0;
                und_q <= 1'b1;
            end
        end
    end

    // Output pulses and their data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
            pv_q <= 1'b0;
            ob_q <= '0;
            pa_q <= '0;
        end else begin
            ov_q <= take_prt && d_print;
            pv_q <= take_prt && d_pi;
            if (take_prt) begin
                ob_q <= d_ch;
                pa_q <= d_arg;
            end
        end
    end

    assign busy      = go_q;
    assign und_flag  = und_q;
    assign dhold     = hold_q;
    assign out_valid = ov_q;
    assign out_byte  = ob_q;
    assign pi_valid  = pv_q;
    assign pi_arg    = pa_q;

    // R8
    und_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(und_q) |-> !go_q);
    // R5
    print_pi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ov_q && pv_q));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_q |=> (!ov_q && !pv_q));
    // R7
    hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_prt && !go_start && !go_stop) |=> (hold_q == $past(rdata[B_DEL])));
endmodule

// File: tb/xlat_top_tb.sv
module xlat_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_we = 0, ent_we = 0, go_start = 0, load_mode = 0, go_stop = 0, in_valid = 0;
    logic [7:0]  buf_wdata = 0, in_byte = 0;
    logic [11:0] ent_wdata = 0;
    logic [12:0] rd_word;
    logic        busy, out_valid, pi_valid, und_flag, dhold;
    logic [7:0]  out_byte;
    logic [4:0]  pi_arg;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    xlat_top u_dut (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .ent_we(ent_we), .ent_wdata(ent_wdata), .rd_word(rd_word),
        .go_start(go_start), .load_mode(load_mode), .go_stop(go_stop),
        .in_valid(in_valid), .in_byte(in_byte), .busy(busy),
        .out_valid(out_valid), .out_byte(out_byte), .pi_valid(pi_valid),
        .pi_arg(pi_arg), .und_flag(und_flag), .dhold(dhold)
    );

    // {byte, out_valid, out_byte, pi_valid, pi_arg, und, dhold}
    localparam logic [24:0] VEC [12] = '{
        {8'h61, 1'b1, 8'h41, 1'b0, 5'd0,  1'b0, 1'b0},  // R3
        {8'h62, 1'b1, 8'h62, 1'b0, 5'd0,  1'b0, 1'b0},  // R4
        {8'h2C, 1'b1, 8'h2C, 1'b0, 5'd0,  1'b0, 1'b1},  // R7
        {8'h62, 1'b1, 8'h55, 1'b0, 5'd0,  1'b0, 1'b0},  // R7
        {8'h0A, 1'b0, 8'h00, 1'b1, 5'd7,  1'b0, 1'b0},  // R5
        {8'h0D, 1'b0, 8'h00, 1'b1, 5'd16, 1'b0, 1'b0},  // R5
        {8'h00, 1'b0, 8'h00, 1'b0, 5'd0,  1'b0, 1'b0},  // R6
        {8'h30, 1'b0, 8'h00, 1'b0, 5'd0,  1'b0, 1'b0},  // R6
        {8'h2C, 1'b1, 8'h2C, 1'b0, 5'd0,  1'b0, 1'b1},  // R7
        {8'h0C, 1'b0, 8'h00, 1'b1, 5'd0,  1'b0, 1'b0},  // R7
        {8'h7F, 1'b1, 8'h7F, 1'b0, 5'd0,  1'b1, 1'b0},  // R8
        {8'h61, 1'b0, 8'h00, 1'b0, 5'd0,  1'b1, 1'b0}   // R8
    };

    function automatic string vtag(input int i);
        case (i)
            0: vtag = "R3";  1: vtag = "R4";  2, 3, 8, 9: vtag = "R7";
            4, 5: vtag = "R5";  6, 7: vtag = "R6";  default: vtag = "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_buf(input logic [7:0] v);
        buf_we = 1; buf_wdata = v; @(posedge clk); @(negedge clk); buf_we = 0;
    endtask
    task automatic put_entry(input logic [7:0] idx, input logic [11:0] v);
        set_buf(idx);
        ent_we = 1; ent_wdata = v; @(posedge clk); @(negedge clk); ent_we = 0;
    endtask
    task automatic read_entry(input logic [7:0] idx, output logic [12:0] v);
        set_buf(idx); v = rd_word;
    endtask
    task automatic start(input logic ld);
        go_start = 1; load_mode = ld; @(posedge clk); @(negedge clk); go_start = 0;
    endtask
    task automatic stop();
        go_stop = 1; @(posedge clk); @(negedge clk); go_stop = 0;
    endtask
    task automatic send(input logic [7:0] b);
        in_valid = 1; in_byte = b; @(posedge clk); @(negedge clk); in_valid = 0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [12:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state and default entries
        check("R1 busy", busy, 0);
        check("R1 und", und_flag, 0);
        check("R1 dhold", dhold, 0);
        read_entry(8'h0A, rv); check("R1 entry 0A", rv, 13'h1307);
        read_entry(8'h0B, rv); check("R1 entry 0B", rv, 13'h0306);
        read_entry(8'h0C, rv); check("R1 entry 0C", rv, 13'h0300);
        read_entry(8'h0D, rv); check("R1 entry 0D", rv, 13'h1310);
        read_entry(8'h41, rv); check("R1 entry 41", rv, 13'h0000);
        // R2 host write and parity readback
        put_entry(8'h61, 12'h241); read_entry(8'h61, rv); check("R2 rd 61", rv, 13'h1241);
        put_entry(8'h62, 12'h055); read_entry(8'h62, rv); check("R2 rd 62", rv, 13'h0055);
        put_entry(8'h2C, 12'h42C);
        put_entry(8'h30, 12'h200);
        put_entry(8'h7F, 12'h800);
        // R11 idle stream ignored
        send(8'h61);
        check("R11 idle out", {out_valid, pi_valid}, 0);
        // R12 vector walk in a print run
        start(1'b0);
        check("R12 busy", busy, 1);
        for (int i = 0; i < 12; i++) begin
            send(VEC[i][24:17]);
            check(vtag(i), {out_valid, pi_valid, und_flag, dhold},
                  {VEC[i][16], VEC[i][7], VEC[i][1], VEC[i][0]});
            if (VEC[i][16]) check(vtag(i), out_byte, VEC[i][15:8]);
            if (VEC[i][7])  check(vtag(i), pi_arg, VEC[i][6:2]);
        end
        check("R8 run ended", busy, 0);
        // R10 start clears und
        start(1'b0);
        check("R10 und cleared", und_flag, 0);
        // R11 host write during run ignored
        buf_we = 1; buf_wdata = 8'h50; @(posedge clk); @(negedge clk); buf_we = 0;
        ent_we = 1; ent_wdata = 12'hFFF; @(posedge clk); @(negedge clk); ent_we = 0;
        stop();
        read_entry(8'h50, rv); check("R11 busy write ignored", rv, 13'h0000);
        // R9 load run of byte pairs
        start(1'b1);
        send(8'h34); send(8'h0A); send(8'h41); send(8'h02);
        stop();
        read_entry(8'h00, rv); check("R9 entry 0", rv, 13'h1A34);
        read_entry(8'h01, rv); check("R9 entry 1", rv, 13'h1241);
        start(1'b0);
        send(8'h01);
        check("R9 loaded entry used", {out_valid, out_byte}, {1'b1, 8'h41});
        stop();
        // R10 load restarts at index 0
        start(1'b1);
        send(8'h77); send(8'h00);
        stop();
        read_entry(8'h00, rv); check("R10 index reset", rv, 13'h0077);
        read_entry(8'h01, rv); check("R10 entry 1 kept", rv, 13'h1241);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule